// File: doc/BRIEF.md
# Dual-Channel DMA Status Tracker

This block follows two DMA channels through their lives and presents each channel's state as a status word. A transfer engine outside the block reports three things: the last transfer of a channel has been issued, external accesses are still in flight, and per-access attributes. The tracker uses these to decide when a channel may start, when it has finished, and whether it ended in error. A channel that is asked to start while the other one is busy waits in a queue and starts by itself once the other channel is no longer running.

On an error the block records an error-source code and, for every error other than an external one, the faulting address. It then drives one of three active-low interrupt lines. A channel marked secure uses the secure line and a non-secure channel uses the non-secure line. An abort during a page-table walk done for the DMA also drives a separate external-error line. A coprocessor-style register port reads the status word of the channel picked by a channel-select register. Each access gets a one-cycle response, either data or an undefined-instruction signal, based on privilege, security state and per-channel user-access bits.

Top module: `dma_chan_tracker`

## Requirements
- R1: After reset both channels read Idle, the error-source code is 0, all three interrupt lines are high, and no register response is pending. The status word holds the state in bits [2:0] (Idle=0, Queued=1, Running=2, Complete=3, Error=4) and the error-source code in bits [11:7]. All other bits are 0.
- R2: A start request on an Idle, Complete or Error channel makes it Queued at the next clock edge and clears its error-source code. A start request on a Running or Queued channel has no effect.
- R3: A Queued channel becomes Running at the next edge if the other channel is not Running. When both channels are Queued, channel 0 goes first and channel 1 stays Queued. The two channels are never Running together.
- R4: A Running channel leaves Running only when two things hold: the end of its transfer (last-transfer flag or an error) was registered at an earlier edge, and its outstanding-access input is low. It then becomes Error if an error was recorded and Complete otherwise.
- R5: An access is an Unshared error (code 5'b00001) when it hits the TCM range, or when it targets an unshared location and either its user flag or the channel's UM bit is set. An unshared access with neither flag set is not an error. The faulting address is captured for that channel.
- R6: An access with an external abort records code 5'b11010 and leaves the captured fault address unchanged. Only the first error of a run is kept.
- R7: The secure interrupt is low while a secure channel is in Error and the secure mask is low. The non-secure interrupt behaves the same way for non-secure channels and the non-secure mask.
- R8: A page-table-walk abort on a Running channel records code 5'b11010 and drives the external-error interrupt low, unless masked. The line stays low until that channel is started again.
- R9: Each register access gets exactly one response in the next cycle. A write always gets undefined. A read returns the status word when it comes from a secure privileged access, from a non-secure privileged access with the non-secure enable set, from a secure user access with the selected channel's user bit set, or from a non-secure user access with both set. Any other read gets undefined with read data 0.
- R10: The channel-select register picks which channel's status word is read, which channel's user bit applies, and which channel's fault address appears on the fault-address output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 2 | Per-channel start request |
| chan_secure | input | 2 | Per-channel secure configuration |
| chan_um | input | 2 | Per-channel UM control bit |
| chan_uacc | input | 2 | Per-channel user read-access bit |
| xfer_last | input | 2 | Last transfer of channel issued |
| xfer_pend | input | 2 | External accesses still outstanding |
| acc_valid | input | 1 | Access attribute report valid |
| acc_ch | input | 1 | Channel of reported access |
| acc_addr | input | ADDR_W | External address of access |
| acc_shared | input | 1 | Location marked shared |
| acc_user | input | 1 | Transfer issued in user mode |
| acc_tcm | input | 1 | Address falls in TCM range |
| acc_ext_abort | input | 1 | External abort on access |
| ptw_abort | input | 1 | External abort on page-table walk |
| ptw_ch | input | 1 | Channel of the walk |
| mask_sec | input | 1 | Mask for secure interrupt |
| mask_nsec | input | 1 | Mask for non-secure interrupt |
| mask_ext | input | 1 | Mask for external-error interrupt |
| sel_we | input | 1 | Write channel-select register |
| sel_ch | input | 1 | New channel-select value |
| reg_req | input | 1 | Register access request |
| reg_write | input | 1 | Access is a write |
| reg_priv | input | 1 | Access is privileged |
| reg_nonsec | input | 1 | Access is non-secure |
| ns_dma_en | input | 1 | Non-secure access enable |
| status0 | output | 12 | Status word of channel 0 |
| status1 | output | 12 | Status word of channel 1 |
| fault_addr_sel | output | ADDR_W | Fault address of selected channel |
| n_irq_sec | output | 1 | Secure error interrupt, active low |
| n_irq_nsec | output | 1 | Non-secure error interrupt, active low |
| n_irq_ext | output | 1 | Page-table-walk abort interrupt, active low |
| reg_rvalid | output | 1 | Read data valid pulse |
| reg_undef | output | 1 | Undefined response pulse |
| reg_rdata | output | 12 | Read data |

## Verification
The bench holds the outstanding-access input high after a channel's last transfer. A design that completes on the last-transfer flag alone would then show Complete too early. It follows an external abort with a second, unshared error in the same run. This catches a design that overwrites the first code or stores the aborted address in place of the earlier fault address. It starts both channels in the same cycle, which exposes promotion logic that runs both channels or favours channel 1. It also walks all 32 combinations of write, privilege, security, non-secure enable and user bit through the register port, so a wrong gate in the permission rule returns data where undefined is due, or the reverse.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

    localparam int NUM_CH  = 2;
    localparam int CH_W    = 1;
    localparam int STAT_W  = 12;
    localparam int ES_W    = 5;
    localparam int ES_LSB  = 7;
    localparam int ST_W    = 3;

    typedef enum logic [ST_W-1:0] {
        CS_IDLE     = 3'd0,
        CS_QUEUED   = 3'd1,
        CS_RUNNING  = 3'd2,
        CS_COMPLETE = 3'd3,
        CS_ERROR    = 3'd4
    } chan_state_e;

    localparam logic [ES_W-1:0] ES_NONE     = 5'b00000;
    localparam logic [ES_W-1:0] ES_UNSHARED = 5'b00001;
    localparam logic [ES_W-1:0] ES_EXTERNAL = 5'b11010;

    function automatic logic [ES_W-1:0] classify_access(
        input logic ext_abort,
        input logic tcm_hit,
        input logic shared,
        input logic user,
        input logic um
    );
        if (ext_abort)
            return ES_EXTERNAL;
        if (tcm_hit || (!shared && (user || um)))
            return ES_UNSHARED;
        return ES_NONE;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(
        input logic [ES_W-1:0] es,
        input chan_state_e     st
    );
        logic [STAT_W-1:0] w;
        w = '0;
        w[ES_LSB +: ES_W] = es;
        w[ST_W-1:0]       = st;
        return w;
    endfunction

endpackage

// File: rtl/dma_trk_channel.sv
module dma_trk_channel
    import dma_trk_pkg::*;
#(
    parameter int   ADDR_W   = 32,
    parameter logic LOW_PRIO = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  chan_state_e       other_st,
    input  logic              um,
    input  logic              last,
    input  logic              pend,
    input  logic              acc_hit,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_shared,
    input  logic              acc_user,
    input  logic              acc_tcm,
    input  logic              acc_ext,
    input  logic              ptw_hit,
    output chan_state_e       state,
    output logic [ES_W-1:0]   es,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              ptw_flag
);

    typedef struct packed {
        chan_state_e       state;
        logic [ES_W-1:0]   es;
        logic [ADDR_W-1:0] fault;
        logic              done;
        logic              err;
        logic              ptw;
    } ch_reg_t;

    ch_reg_t ch_d, ch_q;
    logic [ES_W-1:0] code;
    logic            may_promote;

    always_comb begin
        code = classify_access(acc_ext, acc_tcm, acc_shared, acc_user, um);
        may_promote = (other_st != CS_RUNNING) &&
                      !(LOW_PRIO && other_st == CS_QUEUED);
        ch_d = ch_q;
        unique case (ch_q.state)
            CS_IDLE, CS_COMPLETE, CS_ERROR: begin
                if (start) begin
                    ch_d.state = CS_QUEUED;
                    ch_d.es    = ES_NONE;
                    ch_d.done  = 1'b0;
                    ch_d.err   = 1'b0;
                    ch_d.ptw   = 1'b0;
                end
            end
            CS_QUEUED: begin
                if (may_promote)
                    ch_d.state = CS_RUNNING;
            end
            CS_RUNNING: begin
                if (!ch_q.err) begin
                    if (acc_hit && code != ES_NONE) begin
                        ch_d.err = 1'b1;
                        ch_d.es  = code;
                        if (code != ES_EXTERNAL)
                            ch_d.fault = acc_addr;
                    end else if (ptw_hit) begin
                        ch_d.err = 1'b1;
                        ch_d.es  = ES_EXTERNAL;
                    end
                end
                if (ptw_hit)
                    ch_d.ptw = 1'b1;
                if (last)
                    ch_d.done = 1'b1;
                if ((ch_q.done || ch_q.err) && !pend)
                    ch_d.state = ch_q.err ? CS_ERROR : CS_COMPLETE;
            end
            default: ch_d.state = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '{state: CS_IDLE, es: ES_NONE, fault: '0,
                      done: 1'b0, err: 1'b0, ptw: 1'b0};
        end else begin
            ch_q <= ch_d;
        end
    end

    assign state      = ch_q.state;
    assign es         = ch_q.es;
    assign fault_addr = ch_q.fault;
    assign ptw_flag   = ch_q.ptw;

endmodule

// File: rtl/dma_trk_regport.sv
module dma_trk_regport
    import dma_trk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sel_we,
    input  logic [CH_W-1:0]               sel_in,
    input  logic                          req,
    input  logic                          write,
    input  logic                          priv,
    input  logic                          nonsec,
    input  logic                          ns_en,
    input  logic [NUM_CH-1:0]             u_bits,
    input  logic [NUM_CH-1:0][STAT_W-1:0] status_all,
    output logic [CH_W-1:0]               chsel,
    output logic                          rvalid,
    output logic                          undef,
    output logic [STAT_W-1:0]             rdata
);

    typedef struct packed {
        logic [CH_W-1:0]   chsel;
        logic              rvalid;
        logic              undef;
        logic [STAT_W-1:0] rdata;
    } rp_reg_t;

    rp_reg_t rp_d, rp_q;
    logic    granted;

    always_comb begin
        granted = !write && (priv || u_bits[rp_q.chsel]) && (!nonsec || ns_en);
        rp_d        = rp_q;
        rp_d.rvalid = 1'b0;
        rp_d.undef  = 1'b0;
        rp_d.rdata  = '0;
        if (sel_we)
            rp_d.chsel = sel_in;
        if (req) begin
            if (granted) begin
                rp_d.rvalid = 1'b1;
                rp_d.rdata  = status_all[rp_q.chsel];
            end else begin
                rp_d.undef = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign chsel  = rp_q.chsel;
    assign rvalid = rp_q.rvalid;
    assign undef  = rp_q.undef;
    assign rdata  = rp_q.rdata;

endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
    import dma_trk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              start_req,
    input  logic [1:0]              chan_secure,
    input  logic [1:0]              chan_um,
    input  logic [1:0]              chan_uacc,
    input  logic [1:0]              xfer_last,
    input  logic [1:0]              xfer_pend,
    input  logic                    acc_valid,
    input  logic                    acc_ch,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    acc_shared,
    input  logic                    acc_user,
    input  logic                    acc_tcm,
    input  logic                    acc_ext_abort,
    input  logic                    ptw_abort,
    input  logic                    ptw_ch,
    input  logic                    mask_sec,
    input  logic                    mask_nsec,
    input  logic                    mask_ext,
    input  logic                    sel_we,
    input  logic                    sel_ch,
    input  logic                    reg_req,
    input  logic                    reg_write,
    input  logic                    reg_priv,
    input  logic                    reg_nonsec,
    input  logic                    ns_dma_en,
    output logic [STAT_W-1:0]       status0,
    output logic [STAT_W-1:0]       status1,
    output logic [ADDR_W-1:0]       fault_addr_sel,
    output logic                    n_irq_sec,
    output logic                    n_irq_nsec,
    output logic                    n_irq_ext,
    output logic                    reg_rvalid,
    output logic                    reg_undef,
    output logic [STAT_W-1:0]       reg_rdata
);

    chan_state_e                    st   [NUM_CH];
    logic [NUM_CH-1:0][ES_W-1:0]    es_v;
    logic [NUM_CH-1:0][ADDR_W-1:0]  fault_v;
    logic [NUM_CH-1:0][STAT_W-1:0]  stat_v;
    logic [NUM_CH-1:0]              in_err;
    logic [NUM_CH-1:0]              ptw_v;
    logic [CH_W-1:0]                chsel;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int              OTHER = NUM_CH - 1 - i;
        localparam logic [CH_W-1:0] IDX   = CH_W'(i);

        dma_trk_channel #(
            .ADDR_W  (ADDR_W),
            .LOW_PRIO(i != 0)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start_req[i]),
            .other_st  (st[OTHER]),
            .um        (chan_um[i]),
            .last      (xfer_last[i]),
            .pend      (xfer_pend[i]),
            .acc_hit   (acc_valid && acc_ch == IDX),
            .acc_addr  (acc_addr),
            .acc_shared(acc_shared),
            .acc_user  (acc_user),
            .acc_tcm   (acc_tcm),
            .acc_ext   (acc_ext_abort),
            .ptw_hit   (ptw_abort && ptw_ch == IDX),
            .state     (st[i]),
            .es        (es_v[i]),
            .fault_addr(fault_v[i]),
            .ptw_flag  (ptw_v[i])
        );

        assign stat_v[i] = pack_status(es_v[i], st[i]);
        assign in_err[i] = (st[i] == CS_ERROR);
    end

    dma_trk_regport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_in    (sel_ch),
        .req       (reg_req),
        .write     (reg_write),
        .priv      (reg_priv),
        .nonsec    (reg_nonsec),
        .ns_en     (ns_dma_en),
        .u_bits    (chan_uacc),
        .status_all(stat_v),
        .chsel     (chsel),
        .rvalid    (reg_rvalid),
        .undef     (reg_undef),
        .rdata     (reg_rdata)
    );

    always_comb begin
        n_irq_sec  = !((|(in_err &  chan_secure)) && !mask_sec);
        n_irq_nsec = !((|(in_err & ~chan_secure)) && !mask_nsec);
        n_irq_ext  = !((|ptw_v) && !mask_ext);
    end

    assign status0        = stat_v[0];
    assign status1        = stat_v[1];
    assign fault_addr_sel = fault_v[chsel];

endmodule

// File: rtl/dma_trk_checker.sv
module dma_trk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  xfer_pend,
    input logic [1:0]  chan_secure,
    input logic        reg_req,
    input logic        reg_write,
    input logic [11:0] status0,
    input logic [11:0] status1,
    input logic        n_irq_sec,
    input logic        reg_rvalid,
    input logic        reg_undef
);

    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        status0[2:0] <= 3'd4 && status1[2:0] <= 3'd4);

    a_r3_single_runner: assert property (@(posedge clk) disable iff (!rst_n)
        !(status0[2:0] == 3'd2 && status1[2:0] == 3'd2));

    a_r4_hold_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (status0[2:0] == 3'd2 && xfer_pend[0]) |=> status0[2:0] == 3'd2);

    a_r4_hold_ch1: assert property (@(posedge clk) disable iff (!rst_n)
        (status1[2:0] == 3'd2 && xfer_pend[1]) |=> status1[2:0] == 3'd2);

    a_r7_sec_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !n_irq_sec |-> ((status0[2:0] == 3'd4 && chan_secure[0]) ||
                        (status1[2:0] == 3'd4 && chan_secure[1])));

    a_r9_write_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_write) |=> (reg_undef && !reg_rvalid));

    a_r9_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rvalid, reg_undef}));

    a_r9_response_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_req |=> !(reg_rvalid || reg_undef));

endmodule

bind dma_chan_tracker dma_trk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_pend  (xfer_pend),
    .chan_secure(chan_secure),
    .reg_req    (reg_req),
    .reg_write  (reg_write),
    .status0    (status0),
    .status1    (status1),
    .n_irq_sec  (n_irq_sec),
    .reg_rvalid (reg_rvalid),
    .reg_undef  (reg_undef)
);

// File: tb/dma_chan_tracker_test.sv
module dma_chan_tracker_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    start_req = '0, chan_secure = 2'b01, chan_um = '0, chan_uacc = '0;
    logic [1:0]    xfer_last = '0, xfer_pend = '0;
    logic          acc_valid = 0, acc_ch = 0, acc_shared = 1, acc_user = 0;
    logic          acc_tcm = 0, acc_ext_abort = 0, ptw_abort = 0, ptw_ch = 0;
    logic [AW-1:0] acc_addr = '0;
    logic          mask_sec = 0, mask_nsec = 0, mask_ext = 0, sel_we = 0, sel_ch = 0;
    logic          reg_req = 0, reg_write = 0, reg_priv = 0, reg_nonsec = 0, ns_dma_en = 0;
    logic [11:0]   status0, status1, reg_rdata;
    logic [AW-1:0] fault_addr_sel;
    logic          n_irq_sec, n_irq_nsec, n_irq_ext, reg_rvalid, reg_undef;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [12:0] sb_q[$];

    always #10 clk = ~clk;

    dma_chan_tracker #(.ADDR_W(AW)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] which);
        start_req = which;
        tick();
        start_req = '0;
    endtask

    task automatic access(input logic ch, input logic [AW-1:0] a, input logic sh,
                          input logic us, input logic tcm, input logic ext);
        acc_valid = 1; acc_ch = ch; acc_addr = a; acc_shared = sh;
        acc_user = us; acc_tcm = tcm; acc_ext_abort = ext;
        tick();
        acc_valid = 0; acc_ext_abort = 0; acc_tcm = 0; acc_shared = 1; acc_user = 0;
    endtask

    task automatic select(input logic ch);
        sel_we = 1; sel_ch = ch;
        tick();
        sel_we = 0;
    endtask

    // Expected grant, spelled per access class
    function automatic logic grant_rule(input logic wr, pv, ns, dma, u);
        if (wr)              return 1'b0;
        if (!ns && pv)       return 1'b1;
        if (ns && pv)        return dma;
        if (!ns && !pv)      return u;
        return u && dma;
    endfunction

    task automatic reg_access(input logic wr, pv, ns, input logic [11:0] word, input logic ok);
        reg_write = wr; reg_priv = pv; reg_nonsec = ns; reg_req = 1;
        sb_q.push_back(ok ? {1'b0, word} : {1'b1, 12'h000});
        tick();
        reg_req = 0;
    endtask

    // Monitor: pops expected responses as the design produces them (R9)
    always @(negedge clk) begin
        if (rst_n && !finished && (reg_rvalid || reg_undef)) begin
            if (sb_q.size() == 0) begin
                check("R9 unexpected response", {reg_undef, reg_rdata}, 13'h0);
            end else begin
                logic [12:0] e;
                e = sb_q.pop_front();
                check("R9 response", {19'h0, reg_undef, reg_rdata}, {19'h0, e});
                check("R9 single pulse", {31'h0, reg_rvalid & reg_undef}, 32'h0);
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 status0", status0, 12'h000);
        check("R1 status1", status1, 12'h000);
        check("R1 irqs", {n_irq_sec, n_irq_nsec, n_irq_ext}, 3'b111);
        check("R1 no response", {reg_rvalid, reg_undef}, 2'b00);

        // R2/R3 start ch0
        start(2'b01);
        check("R2 ch0 queued", status0, 12'h001);
        tick();
        check("R3 ch0 running", status0, 12'h002);

        // R2 start ignored while running; ch1 queues behind ch0
        start(2'b11);
        check("R2 ch0 start ignored", status0, 12'h002);
        check("R2 ch1 queued", status1, 12'h001);
        tick();
        check("R3 ch1 waits", status1, 12'h001);

        // R4 completion waits for outstanding accesses
        xfer_pend = 2'b01; xfer_last = 2'b01;
        tick(); xfer_last = 0;
        tick(2);
        check("R4 ch0 held by pending", status0, 12'h002);
        xfer_pend = 0;
        tick();
        check("R4 ch0 complete", status0, 12'h003);
        check("R3 ch1 still queued", status1, 12'h001);
        tick();
        check("R3 ch1 auto start", status1, 12'h002);

        // R5 unshared, no user/UM: no error
        access(1'b1, 32'h100, 0, 0, 0, 0);
        check("R5 no error", status1, 12'h002);
        // R5 unshared in user mode
        xfer_pend = 2'b10;
        access(1'b1, 32'h1234, 0, 1, 0, 0);
        check("R5 unshared code", status1, 12'h082);
        tick();
        check("R4 error held by pending", status1, 12'h082);
        xfer_pend = 0;
        tick();
        check("R4 ch1 error", status1, 12'h084);
        check("R7 nonsec irq", {n_irq_sec, n_irq_nsec}, 2'b10);
        select(1'b1);
        check("R5 fault addr ch1", fault_addr_sel, 32'h1234);
        mask_nsec = 1;
        tick();
        check("R7 nonsec masked", n_irq_nsec, 1'b1);
        mask_nsec = 0;

        // R9/R10 full permission sweep on ch1
        for (int k = 0; k < 32; k++) begin
            logic wr, pv, ns, dm, u;
            {wr, pv, ns, dm, u} = 5'(k);
            ns_dma_en = dm; chan_uacc = {u, 1'b0};
            reg_access(wr, pv, ns, 12'h084, grant_rule(wr, pv, ns, dm, u));
        end
        // R10 selected channel's U bit applies
        select(1'b0);
        chan_uacc = 2'b10; ns_dma_en = 0;
        reg_access(0, 0, 0, 12'h003, 1'b0);
        reg_access(0, 1, 0, 12'h003, 1'b1);
        chan_uacc = 2'b01;
        reg_access(0, 0, 0, 12'h003, 1'b1);
        chan_uacc = 0;
        tick();

        // R5 TCM hit on ch0 despite shared
        start(2'b01);
        tick();
        check("R3 ch0 restart", status0, 12'h002);
        access(1'b0, 32'h40, 1, 0, 1, 0);
        check("R5 tcm code", status0, 12'h082);
        tick();
        check("R5 ch0 error", status0, 12'h084);
        check("R5 fault addr ch0", fault_addr_sel, 32'h40);
        check("R7 sec irq", n_irq_sec, 1'b0);

        // R5 UM bit on ch1
        start(2'b10);
        check("R2 ch1 es cleared", status1, 12'h001);
        tick();
        chan_um = 2'b10;
        access(1'b1, 32'h77, 0, 0, 0, 0);
        chan_um = 0;
        check("R5 um code", status1, 12'h082);
        tick();
        select(1'b1);
        check("R5 fault addr um", fault_addr_sel, 32'h77);

        // R6 external abort, first error kept, fault address untouched
        start(2'b01);
        tick();
        xfer_pend = 2'b01;
        access(1'b0, 32'hDEAD, 1, 0, 0, 1);
        access(1'b0, 32'h99, 0, 1, 0, 0);
        check("R6 ext code kept", status0, 12'hD02);
        xfer_pend = 0;
        tick();
        check("R6 ch0 error", status0, 12'hD04);
        select(1'b0);
        check("R6 fault addr kept", fault_addr_sel, 32'h40);

        // R8 page-table-walk abort on ch1
        start(2'b10);
        check("R8 ext irq idle", n_irq_ext, 1'b1);
        tick();
        ptw_abort = 1; ptw_ch = 1;
        tick();
        ptw_abort = 0;
        check("R8 ext irq low", n_irq_ext, 1'b0);
        check("R8 ptw code", status1, 12'hD02);
        tick();
        check("R8 ch1 error", status1, 12'hD04);
        mask_ext = 1;
        tick();
        check("R8 ext masked", n_irq_ext, 1'b1);
        mask_ext = 0;
        start(2'b10);
        check("R8 ext cleared by start", n_irq_ext, 1'b1);
        tick();
        xfer_last = 2'b10;
        tick(); xfer_last = 0;
        tick();
        check("R4 ch1 complete", status1, 12'h003);

        // R3 simultaneous start: ch0 first
        start(2'b11);
        check("R2 both queued", {status0, status1}, {12'h001, 12'h001});
        tick();
        check("R3 ch0 priority", {status0, status1}, {12'h002, 12'h001});
        xfer_last = 2'b01;
        tick(); xfer_last = 0;
        tick();
        check("R3 ch0 done", status0, 12'h003);
        tick();
        check("R3 ch1 follows", status1, 12'h002);

        tick(2);
        check("R9 scoreboard drained", sb_q.size(), 0);
        summary();
    end

endmodule